// File: doc/BRIEF.md
# Banked Interrupt Enable and Status Aggregator

This block collects a set of already-conditioned interrupt lines and turns them into one request toward a parent interrupt controller. The lines are grouped into banks of 32. Each line has a pending input, a software-forced pending bit and an enable bit. Firmware reads the masked status of a bank and services the set bits from the lowest bit upward. It can also read the unmasked status to see every asserted source.

Enable bits and forced bits are never written as a whole register. Each has one address that sets bits where the written word holds a 1 and another address that clears them, so one source can be changed without a read-modify-write race. Several copies of the block can sit at different base offsets of one register window and take the same input lines. Each copy routes whatever subset of sources its own enables select. The base offset is a parameter of each copy. Accesses that fall outside a copy's own window do not affect it.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every enable bit and every forced bit is 0, `irq_req_o` is 0 and `rdata_o` is 0.
- R2: The unmasked status word, at bank offset 0x04, reads as the OR of the bank's input lines and its forced bits, whatever the enables are.
- R3: The masked status word, at bank offset 0x00, reads as the unmasked status ANDed with the bank's enable bits.
- R4: A write to bank offset 0x08 sets each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R5: A write to bank offset 0x0C clears each enable bit whose data bit is 1. Bits written as 0 keep their value.
- R6: Writes to bank offsets 0x10 and 0x14 set and clear the forced bits respectively, in the same write-one manner as the enables.
- R7: Bank k begins k*0x18 bytes above `BASE_ADDR`. Bit i of bank k corresponds to input line k*32+i, so lines 32..63 live in the bank at +0x18.
- R8: `irq_req_o` equals, one clock later, the OR of all bits of every bank's masked status.
- R9: A read returns its data on `rdata_o` in the cycle after `rd_en_i`. Reads of 0x08 and 0x0C both return the bank's enable word. Reads of 0x10 and 0x14 both return its forced word. `rdata_o` holds its value between reads.
- R10: Addresses below `BASE_ADDR`, or at or beyond `BASE_ADDR` + NUM_BANKS*0x18, change no state, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lines_i | input | NUM_BANKS*BANK_W | Conditioned interrupt lines, line n on bit n |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Byte address in the shared register window |
| wdata_i | input | BANK_W | Write data |
| rdata_o | output | BANK_W | Registered read data |
| irq_req_o | output | 1 | Registered request to the parent controller |

## Verification
The lines are driven with sparse patterns that differ between the two banks. With all enables off, reading the unmasked status tells the input path apart from the mask path. Enables are then built up and torn down one bit at a time, with zero-data writes in between, which separates true write-one behaviour from plain register writes. The high bank is reached only through a forced bit, and then through a single line toggled while `irq_req_o` is sampled before and after one edge. This exposes a wrong bank stride, a wrong line-to-bit mapping and a missing or extra request register. Writes just below and just beyond the window show whether the base and window decode are exact.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
  localparam int BANK_STRIDE = 24;   // bytes between consecutive banks

  typedef enum logic [2:0] {
    RG_STAT   = 3'd0,
    RG_RAW    = 3'd1,
    RG_EN_SET = 3'd2,
    RG_EN_CLR = 3'd3,
    RG_SW_SET = 3'd4,
    RG_SW_CLR = 3'd5
  } reg_e;
endpackage

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int BANK_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              in_win,
  input  logic [ADDR_W-1:0] off,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] lines,
  output logic              rd_sel,
  output logic [BANK_W-1:0] rd_val,
  output logic [BANK_W-1:0] status,
  output logic [BANK_W-1:0] en_q,
  output logic [BANK_W-1:0] sw_q
);
  localparam int LO = IDX * BANK_STRIDE;
  localparam int HI = LO + BANK_STRIDE;

  // write-one-to-set / write-one-to-clear update of a mask word
  function automatic logic [BANK_W-1:0] w1_update(
    input logic [BANK_W-1:0] cur,
    input logic [BANK_W-1:0] mask,
    input logic              do_set,
    input logic              do_clr
  );
    if (do_set)      return cur | mask;
    else if (do_clr) return cur & ~mask;
    else             return cur;
  endfunction

  logic [ADDR_W-1:0] loc;
  reg_e              rsel;
  logic              en_set_ev, en_clr_ev, sw_set_ev, sw_clr_ev;
  logic [BANK_W-1:0] raw;

  assign loc    = off - ADDR_W'(LO);
  assign rd_sel = in_win && (off >= ADDR_W'(LO)) && (off < ADDR_W'(HI));
  assign rsel   = reg_e'(loc[4:2]);

  assign en_set_ev = wr_en && rd_sel && (rsel == RG_EN_SET);
  assign en_clr_ev = wr_en && rd_sel && (rsel == RG_EN_CLR);
  assign sw_set_ev = wr_en && rd_sel && (rsel == RG_SW_SET);
  assign sw_clr_ev = wr_en && rd_sel && (rsel == RG_SW_CLR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      sw_q <= '0;
    end else begin
      en_q <= w1_update(en_q, wdata, en_set_ev, en_clr_ev);
      sw_q <= w1_update(sw_q, wdata, sw_set_ev, sw_clr_ev);
    end
  end

  assign raw    = lines | sw_q;
  assign status = raw & en_q;

  always_comb begin
    case (rsel)
      RG_STAT:              rd_val = status;
      RG_RAW:               rd_val = raw;
      RG_EN_SET, RG_EN_CLR: rd_val = en_q;
      RG_SW_SET, RG_SW_CLR: rd_val = sw_q;
      default:              rd_val = '0;
    endcase
  end

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_ev |=> ((en_q & $past(wdata)) == $past(wdata)));
  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_ev |=> ((en_q & $past(wdata)) == '0));
  // R6
  sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_set_ev |=> ((sw_q & $past(wdata)) == $past(wdata)));
  // R6
  sw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_ev |=> ((sw_q & $past(wdata)) == '0));
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int BASE_ADDR = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] lines_i,
  input  logic                        wr_en_i,
  input  logic                        rd_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rdata_o,
  output logic                        irq_req_o
);
  localparam int WIN_BYTES = NUM_BANKS * BANK_STRIDE;

  logic [ADDR_W-1:0]           off;
  logic                        in_win;
  logic [NUM_BANKS-1:0]        sel_b;
  logic [BANK_W-1:0]           rd_b   [NUM_BANKS];
  logic [BANK_W-1:0]           stat_b [NUM_BANKS];
  logic [NUM_BANKS*BANK_W-1:0] en_all, sw_all;
  logic [BANK_W-1:0]           rd_mux;
  logic                        any_pend;

  assign off    = addr_i - ADDR_W'(BASE_ADDR);
  assign in_win = (addr_i >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(WIN_BYTES));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irqagg_bank #(.IDX(b), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en_i),
      .in_win (in_win),
      .off    (off),
      .wdata  (wdata_i),
      .lines  (lines_i[b*BANK_W +: BANK_W]),
      .rd_sel (sel_b[b]),
      .rd_val (rd_b[b]),
      .status (stat_b[b]),
      .en_q   (en_all[b*BANK_W +: BANK_W]),
      .sw_q   (sw_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    rd_mux   = '0;
    any_pend = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (sel_b[b]) rd_mux = rd_mux | rd_b[b];
      any_pend = any_pend | (|stat_b[b]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o   <= '0;
      irq_req_o <= 1'b0;
    end else begin
      if (rd_en_i) rdata_o <= rd_mux;
      irq_req_o <= any_pend;
    end
  end

  // R8
  req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req_o == $past(any_pend)));
  // R10
  win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !in_win) |=> ($stable(en_all) && $stable(sw_all)));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
  // R10
  rd_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !in_win) |=> (rdata_o == '0));
endmodule

// File: tb/tb_irqagg_top.sv
`timescale 1ns/1ps
module tb_irqagg_top;
  localparam int BASE = 'h100;
  localparam int HB   = BASE + 'h18;   // high bank base

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] lines = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_req;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  irqagg_top #(.NUM_BANKS(2), .BANK_W(32), .ADDR_W(10), .BASE_ADDR(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .lines_i(lines), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_req_o(irq_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = 10'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = 10'(a);
    @(negedge clk); rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq_req", 32'(irq_req), 32'h0);
    check("R1 rdata", rdata, 32'h0);
    rd(BASE + 'h08, v); check("R1 enable low", v, 32'h0);
    rd(HB + 'h10, v);   check("R1 forced high", v, 32'h0);
  endtask

  task automatic t_raw();
    logic [31:0] v;
    @(negedge clk); lines = 64'hF0F0_0000_0000_00A5;
    rd(BASE + 'h04, v); check("R2 raw low", v, 32'h0000_00A5);
    rd(HB + 'h04, v);   check("R2 R7 raw high", v, 32'hF0F0_0000);
    rd(BASE + 'h00, v); check("R3 status low masked", v, 32'h0);
    check("R8 no request", 32'(irq_req), 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(BASE + 'h08, 32'h81);
    rd(BASE + 'h08, v); check("R4 R9 enable set", v, 32'h81);
    wr(BASE + 'h08, 32'h0);
    rd(BASE + 'h0C, v); check("R4 R9 zero write keeps", v, 32'h81);
    rd(BASE + 'h00, v); check("R3 status low", v, 32'h81);
    check("R8 request high", 32'(irq_req), 32'h1);
    wr(BASE + 'h0C, 32'h01);
    rd(BASE + 'h0C, v); check("R5 enable clear", v, 32'h80);
    wr(BASE + 'h0C, 32'h0);
    rd(BASE + 'h08, v); check("R5 zero clear keeps", v, 32'h80);
    rd(BASE + 'h00, v); check("R3 status after clear", v, 32'h80);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    @(negedge clk); lines = '0;
    @(negedge clk); check("R8 request drops", 32'(irq_req), 32'h0);
    wr(HB + 'h10, 32'h100);
    rd(HB + 'h14, v);   check("R6 R9 forced set", v, 32'h100);
    rd(HB + 'h04, v);   check("R2 R6 raw from forced", v, 32'h100);
    rd(HB + 'h00, v);   check("R3 forced but disabled", v, 32'h0);
    check("R8 disabled no request", 32'(irq_req), 32'h0);
    wr(HB + 'h08, 32'h100);
    rd(HB + 'h00, v);   check("R7 high bank status", v, 32'h100);
    check("R7 R8 high bank request", 32'(irq_req), 32'h1);
    wr(HB + 'h14, 32'h100);
    rd(HB + 'h04, v);   check("R6 forced clear", v, 32'h0);
    check("R8 request after forced clear", 32'(irq_req), 32'h0);
  endtask

  task automatic t_req_timing();
    @(negedge clk); lines[40] = 1'b1;
    #1 check("R8 registered not yet", 32'(irq_req), 32'h0);
    @(negedge clk); check("R7 R8 line 40 request", 32'(irq_req), 32'h1);
    lines[40] = 1'b0;
    @(negedge clk); check("R8 request falls", 32'(irq_req), 32'h0);
    @(negedge clk); lines[8] = 1'b1;   // low bank bit 8 not enabled
    @(negedge clk); check("R7 line 8 masked", 32'(irq_req), 32'h0);
    lines = '0;
  endtask

  task automatic t_window();
    logic [31:0] v;
    wr(BASE - 'h100 + 'h08, 32'hFFFF_FFFF);      // below window
    wr(BASE + 'h30, 32'hFFFF_FFFF);              // first byte past window
    wr(BASE - 4, 32'hFFFF_FFFF);                 // just below window
    rd(BASE + 'h08, v); check("R10 low enables untouched", v, 32'h80);
    rd(HB + 'h08, v);   check("R10 high enables untouched", v, 32'h100);
    rd(HB + 'h10, v);   check("R10 forced untouched", v, 32'h0);
    rd(BASE + 'h30, v); check("R10 read outside is zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_enable();
    t_soft();
    t_req_timing();
    t_window();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule